// File: doc/BRIEF.md
# Timebase Load Sequencer

This block owns one thread's 64-bit timebase and the control register that governs how it gets its starting value. Software writes and reads a 64-bit control/status word through a plain register port. The timebase does not start by itself: software first arms a load (the machine leaves its reset state and reports that no value is set), then arms a move. The block then waits for the next sync-boundary pulse, accepts the time-of-day value that arrives on a separate load port, and starts counting.

Command bits are self-clearing. Hardware drops them when their step completes. If an armed step never completes, a timeout counter ends the attempt, raises a sticky timeout flag and sends the machine back to reset. A step-error input raises a sticky interrupt flag that is also driven out as a pin. While running, the timebase advances by one every (k+1) clock cycles, where k is the clocks-per-step configuration field.

Top module: `tbase_loader`

## Requirements
- R1: After reset the register reads all zeros (state field [27:24] = 0, the reset state), `tb_value` is zero and `tod_irq` is low.
- R2: Config bits [15:0] (clocks-per-step k in [3:0], sync-select in [7:4], the rest spare) take the written value only when a write occurs in the reset state. Writes to them in any other state leave them unchanged.
- R3: Writing bit 16 as 1 in the reset state makes bit 16 read 1 with the state still 0 for one cycle. One cycle later bit 16 reads 0 and the state reads 1 (not set).
- R4: Writing bit 18 as 1 in the not-set state moves the state to 2 (sync wait) with bit 18 reading 1. A `sync_pulse` in state 2 moves it to 3 (get value).
- R5: In state 3, `tod_valid` loads `tod_value` into the timebase, moves the state to 4 (running) and clears bit 18, all on the same edge.
- R6: `tod_valid` in any state other than 3 leaves the timebase and the state unchanged.
- R7: Bit 16 written outside the reset state, or bit 18 written outside the not-set state, is ignored and reads back 0.
- R8: If an armed command has not completed TMO_LIMIT cycles after the edge that armed it, bit 54 becomes 1, the command bits clear and the state returns to 0. One cycle earlier, none of this has happened yet.
- R9: A `step_err` pulse sets bit 51 and `tod_irq`. They stay set until cleared.
- R10: A write with state field 0 clears bits 51 and 54. From any non-reset state it also forces the state to 0 and cancels the armed commands. The timebase then holds its value.
- R11: In the running state, `tb_value` equals the loaded value plus floor(m/(k+1)) m cycles after the load edge, wrapping modulo 2^64.
- R12: `sync_pulse` outside the sync-wait state has no effect on the state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 64 | Register write data |
| rd_data | output | 64 | Register read data (current contents) |
| sync_pulse | input | 1 | Sync-boundary pulse |
| tod_valid | input | 1 | Load port value strobe |
| tod_value | input | TB_W | Time-of-day value on the load port |
| step_err | input | 1 | Step-error / oscillator fault pulse |
| tb_value | output | TB_W | Current timebase |
| tod_irq | output | 1 | Pending time-of-day interrupt (mirrors bit 51) |

## Verification
The bench goes after the timeout edge: it checks the cycle before expiry and the cycle of expiry. A counter that is off by one would show either a premature reset or a late one. Stray strobes are offered in the wrong states: load values in reset and sync wait, sync pulses in reset, and commands written in the wrong state. A design that honours any of them would show a changed timebase or an unexpected state field. The step rate is checked for every clocks-per-step value, including 0 and a load value just below wrap, where a prescaler that miscounts would drift from floor(m/(k+1)). Forced reset from the running state must clear both sticky flags and freeze the timebase.

// File: rtl/tbase_pkg.sv
package tbase_pkg;
   localparam int REG_W     = 64;
   localparam int CFG_W     = 16;
   localparam int LOAD_BIT  = 16;
   localparam int MOVE_BIT  = 18;
   localparam int STATE_LSB = 24;
   localparam int STATE_W   = 4;
   localparam int IRQ_BIT   = 51;
   localparam int TMO_BIT   = 54;

   typedef enum logic [STATE_W-1:0] {
      ST_RESET     = 4'h0,
      ST_NOT_SET   = 4'h1,
      ST_SYNC_WAIT = 4'h2,
      ST_GET_TOD   = 4'h3,
      ST_RUNNING   = 4'h4
   } tb_state_e;
endpackage

// File: rtl/tbase_seq.sv
module tbase_seq
   import tbase_pkg::*;
#(
   parameter int TMO_LIMIT = 64
) (
   input  logic      clk,
   input  logic      rst_n,
   input  logic      clr_req,
   input  logic      load_req,
   input  logic      move_req,
   input  logic      sync_pulse,
   input  logic      tod_valid,
   output tb_state_e state,
   output logic      load_arm,
   output logic      move_arm,
   output logic      capture,
   output logic      tmo_fire
);
   localparam int CNT_W = (TMO_LIMIT > 2) ? $clog2(TMO_LIMIT) : 1;
   localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(TMO_LIMIT - 1);

   logic [CNT_W-1:0] tmo_cnt;
   logic             force_rst;
   logic             load_go;
   logic             move_go;
   tb_state_e        state_nx;

   assign force_rst = clr_req && (state != ST_RESET);
   assign load_go   = load_req && (state == ST_RESET) && !load_arm;
   assign move_go   = move_req && (state == ST_NOT_SET) && !force_rst;
   assign capture   = (state == ST_GET_TOD) && tod_valid && !force_rst;
   assign tmo_fire  = (load_arm || move_arm) && (tmo_cnt == CNT_LAST)
                      && !force_rst && !capture;

   always_comb begin
      state_nx = state;
      if (force_rst || tmo_fire) begin
         state_nx = ST_RESET;
      end else begin
         case (state)
            ST_RESET:     if (load_arm)   state_nx = ST_NOT_SET;
            ST_NOT_SET:   if (move_go)    state_nx = ST_SYNC_WAIT;
            ST_SYNC_WAIT: if (sync_pulse) state_nx = ST_GET_TOD;
            ST_GET_TOD:   if (capture)    state_nx = ST_RUNNING;
            default:      state_nx = state;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_RESET;
         load_arm <= 1'b0;
         move_arm <= 1'b0;
         tmo_cnt  <= '0;
      end else begin
         state <= state_nx;
         if (force_rst || tmo_fire) begin
            load_arm <= 1'b0;
            move_arm <= 1'b0;
            tmo_cnt  <= '0;
         end else begin
            if (load_arm)     load_arm <= 1'b0;
            else if (load_go) load_arm <= 1'b1;
            if (capture)      move_arm <= 1'b0;
            else if (move_go) move_arm <= 1'b1;
            if (load_go || move_go)        tmo_cnt <= '0;
            else if (load_arm || move_arm) tmo_cnt <= tmo_cnt + 1'b1;
         end
      end
   end

   // R3: the load command lives exactly one cycle and lands in not-set
   p_load_done_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (load_arm && !tmo_fire) |=> (!load_arm && state == ST_NOT_SET));
   // R7: never two commands in flight
   p_arm_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({load_arm, move_arm}));
   // R4: the move command is only held while waiting for sync or value
   p_move_state_r4: assert property (@(posedge clk) disable iff (!rst_n)
      move_arm |-> (state == ST_SYNC_WAIT || state == ST_GET_TOD));
   // R5: a value in get-value lands in running with the command cleared
   p_capture_r5: assert property (@(posedge clk) disable iff (!rst_n)
      capture |=> (state == ST_RUNNING && !move_arm));
   // R8: expiry returns to reset with nothing armed
   p_timeout_r8: assert property (@(posedge clk) disable iff (!rst_n)
      tmo_fire |=> (state == ST_RESET && !load_arm && !move_arm));
   // R12: running is left only by a clearing write
   p_run_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_RUNNING && !clr_req) |=> state == ST_RUNNING);
endmodule

// File: rtl/tbase_regs.sv
module tbase_regs
   import tbase_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [CFG_W-1:0] wr_cfg,
   input  tb_state_e        state,
   input  logic             clr_req,
   input  logic             step_err,
   input  logic             tmo_fire,
   output logic [CFG_W-1:0] cfg,
   output logic             irq_q,
   output logic             tmo_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg   <= '0;
         irq_q <= 1'b0;
         tmo_q <= 1'b0;
      end else begin
         if (wr_en && state == ST_RESET) cfg <= wr_cfg;
         if (step_err)     irq_q <= 1'b1;
         else if (clr_req) irq_q <= 1'b0;
         if (tmo_fire)     tmo_q <= 1'b1;
         else if (clr_req) tmo_q <= 1'b0;
      end
   end

   // R2: configuration is frozen outside reset
   p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state != ST_RESET) |=> $stable(cfg));
   // R9: interrupt flag is sticky until cleared
   p_irq_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_q && !clr_req) |=> irq_q);
   // R10: a clear with no new event drops both flags
   p_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_req && !step_err && !tmo_fire) |=> (!irq_q && !tmo_q));
endmodule

// File: rtl/tbase_count.sv
module tbase_count #(
   parameter int TB_W  = 64,
   parameter int CPS_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [TB_W-1:0]   tod_value,
   input  logic              running,
   input  logic [CPS_PW-1:0] cps,
   output logic [TB_W-1:0]   tb
);
   localparam int CPS_PW = (CPS_W > 0) ? CPS_W : 1;

   logic step;

   generate
      if (CPS_W == 0) begin : g_every_cycle
         assign step = running;
      end else begin : g_prescale
         logic [CPS_W-1:0] pre;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                     pre <= '0;
            else if (capture)               pre <= '0;
            else if (running && pre == cps) pre <= '0;
            else if (running)               pre <= pre + 1'b1;
         end
         assign step = running && (pre == cps);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       tb <= '0;
      else if (capture) tb <= tod_value;
      else if (step)    tb <= tb + 1'b1;
   end

   // R11: between loads the timebase moves by at most one per cycle
   p_step_r11: assert property (@(posedge clk) disable iff (!rst_n)
      !capture |=> (tb == $past(tb) || tb == $past(tb) + 1'b1));
   // R10: outside running and with no load, the timebase holds
   p_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (!running && !capture) |=> $stable(tb));
endmodule

// File: rtl/tbase_loader.sv
module tbase_loader
   import tbase_pkg::*;
#(
   parameter int TB_W      = 64,
   parameter int CPS_W     = 4,
   parameter int TMO_LIMIT = 64
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [REG_W-1:0]  wr_data,
   output logic [REG_W-1:0]  rd_data,
   input  logic              sync_pulse,
   input  logic              tod_valid,
   input  logic [TB_W-1:0]   tod_value,
   input  logic              step_err,
   output logic [TB_W-1:0]   tb_value,
   output logic              tod_irq
);
   localparam int CPS_PW = (CPS_W > 0) ? CPS_W : 1;

   if (TB_W < 1 || TB_W > 64) begin : g_bad_tbw
      $error("tbase_loader: TB_W must be 1..64");
   end
   if (CPS_W > 8) begin : g_bad_cps
      $error("tbase_loader: CPS_W must not exceed 8");
   end
   if (TMO_LIMIT < 2) begin : g_bad_tmo
      $error("tbase_loader: TMO_LIMIT must be at least 2");
   end

   tb_state_e        state;
   logic             load_arm, move_arm, capture, tmo_fire;
   logic             clr_req, load_req, move_req;
   logic [CFG_W-1:0] cfg;
   logic             irq_q, tmo_q;
   logic [CPS_PW-1:0] cps;

   assign clr_req  = wr_en && (wr_data[STATE_LSB +: STATE_W] == ST_RESET);
   assign load_req = wr_en && wr_data[LOAD_BIT];
   assign move_req = wr_en && wr_data[MOVE_BIT];

   generate
      if (CPS_W == 0) begin : g_no_cps
         assign cps = '0;
      end else begin : g_cps
         assign cps = cfg[CPS_PW-1:0];
      end
   endgenerate

   tbase_seq #(.TMO_LIMIT(TMO_LIMIT)) u_seq (
      .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .load_req(load_req),
      .move_req(move_req), .sync_pulse(sync_pulse), .tod_valid(tod_valid),
      .state(state), .load_arm(load_arm), .move_arm(move_arm),
      .capture(capture), .tmo_fire(tmo_fire));

   tbase_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_cfg(wr_data[CFG_W-1:0]),
      .state(state), .clr_req(clr_req), .step_err(step_err),
      .tmo_fire(tmo_fire), .cfg(cfg), .irq_q(irq_q), .tmo_q(tmo_q));

   tbase_count #(.TB_W(TB_W), .CPS_W(CPS_W)) u_count (
      .clk(clk), .rst_n(rst_n), .capture(capture), .tod_value(tod_value),
      .running(state == ST_RUNNING), .cps(cps), .tb(tb_value));

   always_comb begin
      rd_data                         = '0;
      rd_data[CFG_W-1:0]              = cfg;
      rd_data[LOAD_BIT]               = load_arm;
      rd_data[MOVE_BIT]               = move_arm;
      rd_data[STATE_LSB +: STATE_W]   = state;
      rd_data[IRQ_BIT]                = irq_q;
      rd_data[TMO_BIT]                = tmo_q;
   end

   assign tod_irq = irq_q;
endmodule

// File: tb/sim_tbase_loader.sv
module sim_tbase_loader;
   localparam int LIM = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [63:0] wr_data = '0;
   logic [63:0] rd_data;
   logic        sync_pulse = 1'b0;
   logic        tod_valid = 1'b0;
   logic [63:0] tod_value = '0;
   logic        step_err = 1'b0;
   logic [63:0] tb_value;
   logic        tod_irq;

   int errors = 0;
   int checks = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   tbase_loader #(.TB_W(64), .CPS_W(4), .TMO_LIMIT(LIM)) u0 (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
      .rd_data(rd_data), .sync_pulse(sync_pulse), .tod_valid(tod_valid),
      .tod_value(tod_value), .step_err(step_err), .tb_value(tb_value),
      .tod_irq(tod_irq));

   function automatic logic [63:0] exp_tb(input logic [63:0] v,
                                          input int k, input int m);
      return v + 64'(m / (k + 1));
   endfunction

   function automatic logic [63:0] mkw(input logic [3:0] st, input bit ld,
                                       input bit mv, input logic [15:0] cfg);
      logic [63:0] w;
      w = '0;
      w[15:0] = cfg;
      w[16] = ld;
      w[18] = mv;
      w[27:24] = st;
      return w;
   endfunction

   task automatic chk(input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   task automatic wr(input logic [63:0] d);
      wr_en = 1'b1; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0; wr_data = '0;
   endtask

   task automatic pulse_sync();
      sync_pulse = 1'b1; @(negedge clk); sync_pulse = 1'b0;
   endtask

   task automatic pulse_tod(input logic [63:0] v);
      tod_valid = 1'b1; tod_value = v; @(negedge clk);
      tod_valid = 1'b0; tod_value = '0;
   endtask

   initial begin
      #(20 * 150000);
      if (!done) begin
         errors++; checks++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      logic [15:0] cfg0;
      logic [63:0] v;
      int k, w, d, seed;
      seed = 7;
      void'($urandom(seed));
      step(3);
      rst_n = 1'b1;
      step(1);
      // R1
      chk("R1 rd_data", rd_data, 64'h0);
      chk("R1 tb_value", tb_value, 64'h0);
      chk("R1 irq", {63'h0, tod_irq}, 64'h0);

      k = 2;
      cfg0 = 16'h5A30 | 16'(k);
      wr(mkw(4'h0, 0, 0, cfg0));
      chk("R2 cfg in reset", {48'h0, rd_data[15:0]}, {48'h0, cfg0});
      pulse_sync(); step(1);
      chk("R12 sync in reset", {60'h0, rd_data[27:24]}, 64'h0);
      pulse_tod(64'hDEAD); step(1);
      chk("R6 tod in reset", tb_value, 64'h0);
      wr(mkw(4'h0, 0, 1, cfg0));
      chk("R7 move in reset", {62'h0, rd_data[18], rd_data[26]}, 64'h0);

      wr(mkw(4'h0, 1, 0, cfg0));
      chk("R3 load armed", {rd_data[16], rd_data[27:24]}, {1'b1, 4'h0});
      step(1);
      chk("R3 load done", {rd_data[16], rd_data[27:24]}, {1'b0, 4'h1});
      wr(mkw(4'h1, 0, 0, 16'h1234));
      chk("R2 cfg frozen", {48'h0, rd_data[15:0]}, {48'h0, cfg0});
      wr(mkw(4'h1, 1, 0, cfg0));
      chk("R7 load outside reset", {rd_data[16], rd_data[27:24]}, {1'b0, 4'h1});

      wr(mkw(4'h1, 0, 1, cfg0));
      chk("R4 sync wait", {rd_data[18], rd_data[27:24]}, {1'b1, 4'h2});
      pulse_tod(64'hBEEF);
      chk("R6 tod in sync wait", {tb_value[59:0], rd_data[27:24]}, {60'h0, 4'h2});
      pulse_sync();
      chk("R4 get value", {60'h0, rd_data[27:24]}, 64'h3);

      v = {$urandom, $urandom};
      pulse_tod(v);
      chk("R5 running", {rd_data[18], rd_data[27:24]}, {1'b0, 4'h4});
      chk("R5 captured", tb_value, v);
      for (int j = 0; j < 4; j++) begin
         w = 1 + j * 3;
         step(w);
         v = v; // keep load value
      end
      chk("R11 rate", tb_value, exp_tb(v, k, 1 + 4 + 7 + 10));

      step_err = 1'b1; @(negedge clk); step_err = 1'b0;
      chk("R9 irq set", {62'h0, rd_data[51], tod_irq}, 64'h3);
      step(3);
      chk("R9 irq sticky", {62'h0, rd_data[51], tod_irq}, 64'h3);

      wr(mkw(4'h0, 0, 0, cfg0));
      chk("R10 forced reset", {rd_data[51], tod_irq, rd_data[27:24]}, 6'h0);
      v = tb_value;
      step(5);
      chk("R10 tb holds", tb_value, v);

      // R8 timeout while waiting for sync
      wr(mkw(4'h0, 1, 0, cfg0)); step(1);
      wr(mkw(4'h1, 0, 1, cfg0));
      step(LIM - 1);
      chk("R8 before expiry", {rd_data[54], rd_data[18], rd_data[27:24]}, {2'b01, 4'h2});
      step(1);
      chk("R8 at expiry", {rd_data[54], rd_data[18], rd_data[27:24]}, {2'b10, 4'h0});
      wr(mkw(4'h0, 0, 0, cfg0));
      chk("R10 tmo cleared", {63'h0, rd_data[54]}, 64'h0);

      // R8 timeout while waiting for the value
      wr(mkw(4'h0, 1, 0, cfg0)); step(1);
      wr(mkw(4'h1, 0, 1, cfg0));
      step(4); pulse_sync();
      step(LIM - 6);
      chk("R8 get value before", {rd_data[54], rd_data[27:24]}, {1'b0, 4'h3});
      step(1);
      chk("R8 get value expiry", {rd_data[54], rd_data[27:24]}, {1'b1, 4'h0});

      // R11 wrap with k = 0
      wr(mkw(4'h0, 0, 0, 16'h0000));
      wr(mkw(4'h0, 1, 0, 16'h0000)); step(1);
      wr(mkw(4'h1, 0, 1, 16'h0000));
      pulse_sync();
      pulse_tod(64'hFFFF_FFFF_FFFF_FFFE);
      step(3);
      chk("R11 wrap", tb_value, 64'h1);

      // random full loads across every step rate
      for (int it = 0; it < 24; it++) begin
         k = it % 16;
         cfg0 = 16'($urandom) & 16'hFFF0 | 16'(k);
         wr(mkw(4'h0, 0, 0, cfg0));
         wr(mkw(4'h0, 1, 0, cfg0)); step(1);
         wr(mkw(4'h1, 0, 1, cfg0));
         d = $urandom % 12;
         step(d);
         pulse_sync();
         v = {$urandom, $urandom};
         pulse_tod(v);
         w = $urandom % 60;
         step(w);
         chk("R11 random rate", tb_value, exp_tb(v, k, w));
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule